// File: doc/BRIEF.md
# Floating-point to 32-bit integer converter

This unit turns one IEEE 754 binary32 or binary64 operand into a 32-bit integer, either two's complement or unsigned. Each accepted operand produces exactly one registered result one clock later, together with three exception flags: invalid operation, inexact and input denormal.

Rounding is toward zero by default. A per-operation select can instead apply the dynamic mode supplied from a floating-point control register. Values outside the integer range, infinities and NaNs do not wrap. They produce saturated or zero results and raise the invalid flag. Subnormal operands can be flushed to zero under a separate control input, and a flush is reported through the input-denormal flag.

The unit sits behind an instruction decoder that already knows the precision, the signedness and the rounding source of the operation. The caller samples the result in the cycle after it presents the operand.

Top module: `f2i32_conv`

## Requirements
- R1: While reset is asserted and after its release, until an operand is accepted, `out_valid`, `result` and all three flags are 0.
- R2: An operand presented with `in_valid`=1 yields `out_valid`=1 with its result and flags on the next clock edge. When `in_valid`=0, `out_valid` drops to 0 and `result` and the flags keep their last values, whatever the other inputs do.
- R3: `is_double`=1 converts the whole 64-bit `opnd` as binary64. `is_double`=0 converts `opnd[31:0]` as binary32 and ignores `opnd[63:32]`.
- R4: `rz_force`=1 rounds toward zero whatever `rmode` holds.
- R5: `rz_force`=0 applies `rmode`, encoded as 00 nearest with ties to even, 01 toward plus infinity, 10 toward minus infinity and 11 toward zero.
- R6: `is_signed`=1 gives a two's complement result in the range -2^31 to 2^31-1. `is_signed`=0 gives an unsigned result in the range 0 to 2^32-1.
- R7: A NaN operand of either sign gives a result of 0 with the invalid flag set and the inexact flag clear.
- R8: When the rounded value is above the range, or the operand is +infinity, the result is 0x7FFFFFFF (signed) or 0xFFFFFFFF (unsigned). When the rounded value is below the range, or the operand is -infinity, the result is 0x80000000 (signed) or 0 (unsigned). Both cases set the invalid flag and clear the inexact flag. The exact values 2^32-1 (unsigned) and -2^31 (signed) convert without any flag.
- R9: For an unsigned conversion, a negative operand that rounds to a magnitude of 0 gives 0 without the invalid flag. A negative operand that rounds to a nonzero magnitude gives 0 with the invalid flag.
- R10: The inexact flag is set exactly when nonzero fraction bits are discarded and the invalid flag is clear. An integral operand, including either zero, raises no flag.
- R11: With `ftz`=1, a subnormal operand gives 0, sets the input-denormal flag and leaves the other two flags clear. With `ftz`=0, a subnormal operand is converted by its value and the input-denormal flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand accepted this cycle |
| opnd | input | 64 | Floating-point operand; binary32 in bits 31:0 |
| is_double | input | 1 | 1 = binary64 operand, 0 = binary32 |
| is_signed | input | 1 | 1 = signed result, 0 = unsigned |
| rz_force | input | 1 | 1 = round toward zero, 0 = use `rmode` |
| rmode | input | 2 | Dynamic rounding mode from the control register |
| ftz | input | 1 | Flush subnormal operands to zero |
| out_valid | output | 1 | Result registered from the previous cycle's operand |
| result | output | 32 | Integer result |
| flag_invalid | output | 1 | Invalid operation |
| flag_inexact | output | 1 | Inexact |
| flag_denorm | output | 1 | Input denormal (operand flushed) |

## Verification
The hardest situation to reach is a rounding increment that carries the magnitude across a range limit. A binary64 operand of 2^31-0.5 rounds up to 2^31 under nearest-even, which turns an in-range value into a signed overflow. It is driven once with nearest-even and once with forced toward-zero, so that the same operand must give invalid in one case and inexact in the other. The same approach drives -0.75 into an unsigned conversion: it passes silently under truncation and is invalid under nearest. A subnormal operand rounded away from zero in the directed modes covers the path where a value below 2^-126 still yields plus or minus one.

// File: rtl/fcvt_pkg.sv
`timescale 1ns/1ps
package fcvt_pkg;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = 52;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int SIG_W    = DP_MAN_W + 1;   // significand with hidden bit
  localparam int EXP_W    = 13;             // signed unbiased exponent

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_PLUS    = 2'b01,
    RM_MINUS   = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_NAN
  } opclass_e;

  typedef struct packed {
    logic                    sign;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
    opclass_e                cls;
  } operand_t;

  // Decide whether the truncated magnitude is incremented.
  function automatic logic round_up(input rmode_e m, input logic neg,
                                    input logic lsb, input logic g,
                                    input logic s);
    case (m)
      RM_NEAREST: return g & (s | lsb);
      RM_PLUS:    return ~neg & (g | s);
      RM_MINUS:   return neg & (g | s);
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fcvt_field_dec.sv
`timescale 1ns/1ps
module fcvt_field_dec
  import fcvt_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 23,
  localparam int BIAS = (1 << (EW - 1)) - 1
) (
  input  logic [EW+MW:0] raw,
  output operand_t       fields
);
  logic [EW-1:0] e_raw;
  logic [MW-1:0] m_raw;

  assign e_raw = raw[EW+MW-1:MW];
  assign m_raw = raw[MW-1:0];

  always_comb begin
    fields.sign = raw[EW+MW];
    fields.sig  = '0;
    fields.sig[SIG_W-2 -: MW] = m_raw;          // fraction left-aligned
    fields.sig[SIG_W-1]       = (e_raw != '0);  // hidden bit
    if (e_raw == '0)
      fields.exp = EXP_W'(1) - EXP_W'(BIAS);
    else
      fields.exp = EXP_W'(e_raw) - EXP_W'(BIAS);
    if (e_raw == '1)
      fields.cls = (m_raw == '0) ? CL_INF : CL_NAN;
    else if (e_raw == '0)
      fields.cls = (m_raw == '0) ? CL_ZERO : CL_SUB;
    else
      fields.cls = CL_NORM;
  end
endmodule

// File: rtl/fcvt_align_round.sv
`timescale 1ns/1ps
module fcvt_align_round
  import fcvt_pkg::*;
#(
  parameter int INT_W = 32,
  localparam int FRAC_B  = 64,
  localparam int TW      = INT_W + FRAC_B,
  localparam int SH_BASE = FRAC_B - (SIG_W - 1)
) (
  input  operand_t       fields,
  input  rmode_e         mode,
  output logic [INT_W:0] mag,
  output logic           huge,
  output logic           lost,
  output logic           bumped
);
  // Fixed point with FRAC_B fraction bits; the top bit returns the
  // sticky of bits pushed out on the right.
  function automatic logic [TW:0] place(input logic [SIG_W-1:0] sig,
                                        input logic signed [EXP_W-1:0] e);
    logic [TW-1:0]           ext;
    logic [SIG_W-1:0]        low;
    logic signed [EXP_W-1:0] sh;
    logic [EXP_W-1:0]        rs;
    ext = TW'(sig);
    sh  = e + EXP_W'(SH_BASE);
    rs  = EXP_W'(-sh);
    if (!sh[EXP_W-1]) return {1'b0, ext << sh};
    low = (rs >= EXP_W'(SIG_W)) ? '1 : ((SIG_W'(1) << rs) - SIG_W'(1));
    return {|(sig & low), ext >> rs};
  endfunction

  logic [TW:0]      placed;
  logic [TW-1:0]    fixed_v;
  logic [INT_W-1:0] int_part;
  logic             guard, sticky;

  always_comb begin
    placed   = place(fields.sig, fields.exp);
    fixed_v  = placed[TW-1:0];
    int_part = fixed_v[TW-1:FRAC_B];
    guard    = fixed_v[FRAC_B-1];
    sticky   = placed[TW] | (|fixed_v[FRAC_B-2:0]);
  end

  assign lost   = guard | sticky;
  assign bumped = round_up(mode, fields.sign, int_part[0], guard, sticky);
  assign mag    = {1'b0, int_part} + {{INT_W{1'b0}}, bumped};
  assign huge   = (fields.cls == CL_INF) ||
                  ((fields.cls == CL_NORM) &&
                   (fields.exp >= $signed(EXP_W'(INT_W))));
endmodule

// File: rtl/fcvt_saturate.sv
`timescale 1ns/1ps
module fcvt_saturate
  import fcvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             neg,
  input  opclass_e         cls,
  input  logic             is_signed,
  input  logic             ftz,
  input  logic [INT_W:0]   mag,
  input  logic             huge,
  input  logic             lost,
  output logic [INT_W-1:0] res,
  output logic             inv,
  output logic             inx,
  output logic             idc,
  output logic             sat_hi,
  output logic             sat_lo
);
  localparam logic [INT_W:0] U_MAX     = {1'b0, {INT_W{1'b1}}};
  localparam logic [INT_W:0] S_MAX     = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0] S_MIN_MAG = {2'b01, {(INT_W-1){1'b0}}};

  logic [INT_W:0] hi_lim, lo_lim;
  logic           flush, is_nan;

  assign hi_lim = is_signed ? S_MAX : U_MAX;
  assign lo_lim = is_signed ? S_MIN_MAG : '0;
  assign flush  = ftz && (cls == CL_SUB);
  assign is_nan = (cls == CL_NAN);
  assign sat_hi = !is_nan && !flush && !neg && (huge || (mag > hi_lim));
  assign sat_lo = !is_nan && !flush &&  neg && (huge || (mag > lo_lim));

  always_comb begin
    res = '0;
    inv = 1'b0;
    inx = 1'b0;
    idc = 1'b0;
    if (is_nan) begin
      inv = 1'b1;
    end else if (flush) begin
      idc = 1'b1;
    end else if (sat_hi) begin
      res = is_signed ? S_MAX[INT_W-1:0] : U_MAX[INT_W-1:0];
      inv = 1'b1;
    end else if (sat_lo) begin
      res = is_signed ? S_MIN_MAG[INT_W-1:0] : '0;
      inv = 1'b1;
    end else begin
      res = neg ? -mag[INT_W-1:0] : mag[INT_W-1:0];
      inx = lost;
    end
  end
endmodule

// File: rtl/f2i32_conv.sv
`timescale 1ns/1ps
module f2i32_conv
  import fcvt_pkg::*;
#(
  parameter int INT_W = 32,
  localparam int OP_W = 1 + DP_EXP_W + DP_MAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  opnd,
  input  logic             is_double,
  input  logic             is_signed,
  input  logic             rz_force,
  input  logic [1:0]       rmode,
  input  logic             ftz,
  output logic             out_valid,
  output logic [INT_W-1:0] result,
  output logic             flag_invalid,
  output logic             flag_inexact,
  output logic             flag_denorm
);
  operand_t         dp_f, sp_f, op_f;
  rmode_e           eff_mode;
  logic [INT_W:0]   mag_w;
  logic             huge_w, lost_w, bumped_w;
  logic [INT_W-1:0] res_w;
  logic             inv_w, inx_w, idc_w, sat_hi_w, sat_lo_w;
  logic             is_nan_w, is_sub_w;

  fcvt_field_dec #(.EW(DP_EXP_W), .MW(DP_MAN_W)) u_dp_dec (
    .raw(opnd), .fields(dp_f));
  fcvt_field_dec #(.EW(SP_EXP_W), .MW(SP_MAN_W)) u_sp_dec (
    .raw(opnd[SP_EXP_W+SP_MAN_W:0]), .fields(sp_f));

  assign op_f     = is_double ? dp_f : sp_f;
  assign eff_mode = rz_force ? RM_ZERO : rmode_e'(rmode);
  assign is_nan_w = (op_f.cls == CL_NAN);
  assign is_sub_w = (op_f.cls == CL_SUB);

  fcvt_align_round #(.INT_W(INT_W)) u_round (
    .fields(op_f), .mode(eff_mode), .mag(mag_w), .huge(huge_w),
    .lost(lost_w), .bumped(bumped_w));

  fcvt_saturate #(.INT_W(INT_W)) u_sat (
    .neg(op_f.sign), .cls(op_f.cls), .is_signed(is_signed), .ftz(ftz),
    .mag(mag_w), .huge(huge_w), .lost(lost_w), .res(res_w),
    .inv(inv_w), .inx(inx_w), .idc(idc_w), .sat_hi(sat_hi_w),
    .sat_lo(sat_lo_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
      flag_denorm  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= res_w;
        flag_invalid <= inv_w;
        flag_inexact <= inx_w;
        flag_denorm  <= idc_w;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(flag_invalid));
  // R4
  rz_no_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rz_force |-> !bumped_w);
  // R6
  signed_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_signed && !op_f.sign && !is_nan_w |=> !result[INT_W-1]);
  // R7
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_nan_w |=> flag_invalid && (result == '0));
  // R8
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && sat_hi_w |=> flag_invalid && !flag_inexact && result[INT_W-2]);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_invalid |-> !flag_inexact);
  // R11
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ftz && is_sub_w |=> flag_denorm && (result == '0) && !flag_inexact);
endmodule

// File: tb/sim_f2i32_conv.sv
`timescale 1ns/1ps
module sim_f2i32_conv;
  localparam int VW = 109;
  localparam int NV = 37;
  // {opnd, dbl, sgn, rz, rmode, ftz, result, inv, inx, idc, req}
  localparam logic [VW-1:0] VECS [NV] = '{
    // R4 toward zero regardless of mode
    {64'h00000000_40200000,1'b0,1'b1,1'b1,2'b00,1'b0,32'h00000002,1'b0,1'b1,1'b0,4'd4},
    {64'h00000000_40200000,1'b0,1'b1,1'b1,2'b10,1'b0,32'h00000002,1'b0,1'b1,1'b0,4'd4},
    {64'h00000000_BFC00000,1'b0,1'b1,1'b1,2'b01,1'b0,32'hFFFFFFFF,1'b0,1'b1,1'b0,4'd4},
    // R5 dynamic modes
    {64'h00000000_40200000,1'b0,1'b1,1'b0,2'b00,1'b0,32'h00000002,1'b0,1'b1,1'b0,4'd5},
    {64'h00000000_40600000,1'b0,1'b1,1'b0,2'b00,1'b0,32'h00000004,1'b0,1'b1,1'b0,4'd5},
    {64'h00000000_3F000000,1'b0,1'b1,1'b0,2'b00,1'b0,32'h00000000,1'b0,1'b1,1'b0,4'd5},
    {64'h00000000_3FC00000,1'b0,1'b0,1'b0,2'b00,1'b0,32'h00000002,1'b0,1'b1,1'b0,4'd5},
    {64'h00000000_40200000,1'b0,1'b1,1'b0,2'b01,1'b0,32'h00000003,1'b0,1'b1,1'b0,4'd5},
    {64'h00000000_C0200000,1'b0,1'b1,1'b0,2'b01,1'b0,32'hFFFFFFFE,1'b0,1'b1,1'b0,4'd5},
    {64'h00000000_C0200000,1'b0,1'b1,1'b0,2'b10,1'b0,32'hFFFFFFFD,1'b0,1'b1,1'b0,4'd5},
    {64'h00000000_C0200000,1'b0,1'b1,1'b0,2'b11,1'b0,32'hFFFFFFFE,1'b0,1'b1,1'b0,4'd5},
    // R3 precision select
    {64'hDEADBEEF_40200000,1'b0,1'b1,1'b1,2'b00,1'b0,32'h00000002,1'b0,1'b1,1'b0,4'd3},
    {64'hDEADBEEF_40200000,1'b1,1'b1,1'b1,2'b00,1'b0,32'h80000000,1'b1,1'b0,1'b0,4'd3},
    {64'h40040000_00000000,1'b1,1'b0,1'b1,2'b00,1'b0,32'h00000002,1'b0,1'b1,1'b0,4'd3},
    // R6 signedness
    {64'h00000000_4F000000,1'b0,1'b0,1'b1,2'b00,1'b0,32'h80000000,1'b0,1'b0,1'b0,4'd6},
    {64'hC1E00000_00000000,1'b1,1'b1,1'b1,2'b00,1'b0,32'h80000000,1'b0,1'b0,1'b0,4'd6},
    {64'h00000000_BF800000,1'b0,1'b1,1'b1,2'b00,1'b0,32'hFFFFFFFF,1'b0,1'b0,1'b0,4'd6},
    // R7 NaN
    {64'h00000000_7FC00000,1'b0,1'b1,1'b1,2'b00,1'b0,32'h00000000,1'b1,1'b0,1'b0,4'd7},
    {64'h7FF80000_00000000,1'b1,1'b0,1'b1,2'b00,1'b0,32'h00000000,1'b1,1'b0,1'b0,4'd7},
    {64'h00000000_FFC00001,1'b0,1'b1,1'b1,2'b00,1'b0,32'h00000000,1'b1,1'b0,1'b0,4'd7},
    // R8 saturation
    {64'h00000000_7F800000,1'b0,1'b1,1'b1,2'b00,1'b0,32'h7FFFFFFF,1'b1,1'b0,1'b0,4'd8},
    {64'h00000000_FF800000,1'b0,1'b0,1'b1,2'b00,1'b0,32'h00000000,1'b1,1'b0,1'b0,4'd8},
    {64'h00000000_4F000000,1'b0,1'b1,1'b1,2'b00,1'b0,32'h7FFFFFFF,1'b1,1'b0,1'b0,4'd8},
    {64'h00000000_4F800000,1'b0,1'b0,1'b1,2'b00,1'b0,32'hFFFFFFFF,1'b1,1'b0,1'b0,4'd8},
    {64'h41EFFFFF_FFE00000,1'b1,1'b0,1'b1,2'b00,1'b0,32'hFFFFFFFF,1'b0,1'b0,1'b0,4'd8},
    {64'h41DFFFFF_FFE00000,1'b1,1'b1,1'b0,2'b00,1'b0,32'h7FFFFFFF,1'b1,1'b0,1'b0,4'd8},
    {64'hC1E00000_00200000,1'b1,1'b1,1'b1,2'b00,1'b0,32'h80000000,1'b1,1'b0,1'b0,4'd8},
    // R9 negative into unsigned
    {64'h00000000_BF400000,1'b0,1'b0,1'b1,2'b00,1'b0,32'h00000000,1'b0,1'b1,1'b0,4'd9},
    {64'h00000000_BF400000,1'b0,1'b0,1'b0,2'b00,1'b0,32'h00000000,1'b1,1'b0,1'b0,4'd9},
    {64'h00000000_BFC00000,1'b0,1'b0,1'b1,2'b00,1'b0,32'h00000000,1'b1,1'b0,1'b0,4'd9},
    // R10 inexact
    {64'h41DFFFFF_FFE00000,1'b1,1'b1,1'b1,2'b00,1'b0,32'h7FFFFFFF,1'b0,1'b1,1'b0,4'd10},
    {64'h00000000_40400000,1'b0,1'b1,1'b1,2'b00,1'b0,32'h00000003,1'b0,1'b0,1'b0,4'd10},
    {64'h00000000_80000000,1'b0,1'b1,1'b0,2'b10,1'b0,32'h00000000,1'b0,1'b0,1'b0,4'd10},
    // R11 subnormals
    {64'h00000000_00000001,1'b0,1'b0,1'b1,2'b00,1'b1,32'h00000000,1'b0,1'b0,1'b1,4'd11},
    {64'h00000000_00000001,1'b0,1'b0,1'b0,2'b01,1'b0,32'h00000001,1'b0,1'b1,1'b0,4'd11},
    {64'h00000000_80000001,1'b0,1'b1,1'b0,2'b10,1'b0,32'hFFFFFFFF,1'b0,1'b1,1'b0,4'd11},
    {64'h00000000_00000001,1'b1,1'b1,1'b0,2'b01,1'b1,32'h00000000,1'b0,1'b0,1'b1,4'd11}
  };

  logic        clk = 1'b0;
  logic        rst_n, in_valid, is_double, is_signed, rz_force, ftz;
  logic [63:0] opnd;
  logic [1:0]  rmode;
  logic        out_valid, flag_invalid, flag_inexact, flag_denorm;
  logic [31:0] result;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  f2i32_conv u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd(opnd),
    .is_double(is_double), .is_signed(is_signed), .rz_force(rz_force),
    .rmode(rmode), .ftz(ftz), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
    .flag_denorm(flag_denorm));

  task automatic chk(input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] outs();
    return {28'd0, out_valid, result, flag_invalid, flag_inexact, flag_denorm};
  endfunction

  task automatic issue(input logic [63:0] op, input logic dbl, input logic sgn,
                       input logic rz, input logic [1:0] rm, input logic fz);
    @(negedge clk);
    opnd = op; is_double = dbl; is_signed = sgn;
    rz_force = rz; rmode = rm; ftz = fz; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; opnd = '0; is_double = 1'b0;
    is_signed = 1'b0; rz_force = 1'b1; rmode = 2'b00; ftz = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state, even with an operand offered
    in_valid = 1'b1; opnd = 64'h40400000;
    @(negedge clk);
    chk("R1 during reset", outs(), 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", outs(), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string tag;
      v = VECS[i];
      issue(v[108:45], v[44], v[43], v[42], v[41:40], v[39]);
      tag = $sformatf("R%0d vector %0d", v[3:0], i);
      chk(tag, outs(), {28'd0, 1'b1, v[38:4]});
    end

    // R2: idle cycle drops out_valid and holds the result
    issue(64'h40A00000, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0);   // 5.0
    chk("R2 one-cycle result", outs(), {28'd0, 1'b1, 32'd5, 3'b000});
    opnd = 64'h7FC00000; is_signed = 1'b0;
    @(negedge clk);
    chk("R2 idle ignores inputs", outs(), {28'd0, 1'b0, 32'd5, 3'b000});
    // R2: back-to-back operands, one result per cycle
    opnd = 64'h40400000; is_signed = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    chk("R2 back-to-back first", outs(), {28'd0, 1'b1, 32'd3, 3'b000});
    opnd = 64'h7F800000;
    @(negedge clk);
    chk("R2 back-to-back second", outs(), {28'd0, 1'b1, 32'h7FFFFFFF, 3'b100});
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 hold after burst", outs(), {28'd0, 1'b0, 32'h7FFFFFFF, 3'b100});
    // R1: reset again clears held values
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reassert", outs(), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule